// File: doc/BRIEF.md
# Floppy Address-Field Identify Sequencer

This block carries one floppy controller command through its three phases: collecting the command bytes, executing, and returning results. The command reports the ID header of the first sector that passes under the head. The host writes an opcode byte and then a select byte into a byte stream. The sequencer takes the wait time for the selected drive from a per-drive configuration bus and waits that long. It then enables the data separator and watches two inputs: the decoded address-field strobe and the index pulse. The command issues no step pulses and never touches the track position.

Execution ends in one of three ways. The first is an address field being found, which is the normal ending. The second is a second index pulse arriving before any field is found, which means the address mark is missing. The third is a host byte written while the command is executing. This last ending is the only way out when no media is present and no index pulses arrive. The outcome goes out as seven bytes on a valid/ready stream: three status bytes, then the four captured header bytes. An interrupt request stays high from the end of execution until the host has taken the last result byte.

Back-pressure works as follows. On the command stream, a byte is consumed on a clock edge where `cmd_valid` and `cmd_ready` are both high. On the result stream, a byte is consumed on a clock edge where `res_valid` and `res_ready` are both high. `res_data` does not change while a byte is offered and not yet taken. `cmd_ready` is held low for the whole result phase, so host writes stall there.

Top module: `fdc_readid_seq`

## Requirements
- R1: While idle, a command byte b with (b & 8'hBF) == 8'h0A (bit 6 may be either value) starts the command and `busy` goes high. Any other byte is consumed and ignored, and `busy` stays low.
- R2: In the second command byte, bit 2 is the head and bits 1:0 are the drive. The first result byte (status 0) has the head in bit 2, the drive in bits 1:0, and bits 5:3 at zero.
- R3: `sep_en` rises exactly N cycles after the clock edge that consumes the second byte. N is `dly_cfg[8*drive +: 8]`. N = 0 means it rises right after that edge.
- R4: The search counts only index pulses seen while `sep_en` is high. The first such pulse does not end execution. The second, with no address strobe in the same cycle, ends it with status 0 bits 7:6 = 01, status 1 = 8'h01, status 2 = 0 and all four ID bytes zero.
- R5: An `am_valid` strobe during the search ends execution normally. It captures track, head, sector and size code, sets status 0 bits 7:6 = 00 and status 1 = status 2 = 0. It takes priority over an index pulse in the same cycle.
- R6: A host byte consumed during the wait or the search aborts the command. The result is status 0 bits 7:6 = 01, status 1 = 0, status 2 = 0 and all four ID bytes zero.
- R7: `irq` and `res_valid` go high on the cycle after execution ends, for every kind of ending. `irq` implies `busy`.
- R8: The result bytes come out in this order: status 0, status 1, status 2, track, head, sector, size code. Each byte holds steady while the host stalls.
- R9: `cmd_ready` is low whenever `res_valid` is high. `sep_en` is high only during the search.
- R10: After the seventh result byte is consumed, `busy`, `irq` and `res_valid` drop, `cmd_ready` returns high, and a new opcode is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command byte offered |
| cmd_ready | output | 1 | Sequencer accepts a command byte |
| cmd_data | input | 8 | Command byte |
| dly_cfg | input | 32 | Per-drive wait in cycles, 8 bits per drive, drive 0 in the low byte |
| sep_en | output | 1 | Data separator enable during the search |
| index_pulse | input | 1 | One-cycle index strobe |
| am_valid | input | 1 | Address field decoded this cycle |
| am_track | input | 8 | Track byte of the decoded field |
| am_head | input | 8 | Head byte of the decoded field |
| am_sector | input | 8 | Sector byte of the decoded field |
| am_size | input | 8 | Size-code byte of the decoded field |
| res_valid | output | 1 | Result byte offered |
| res_ready | input | 1 | Host takes the result byte |
| res_data | output | 8 | Result byte |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Execution finished, results pending |

## Verification
The assertions assume that `index_pulse` and `am_valid` are single-cycle strobes from a separator that the host does not drive during the result phase. They also assume `dly_cfg` holds steady while a wait is counting. The stimulus changes the delay of a drive only while the sequencer is idle. It drives each strobe high for exactly one cycle, and it varies the ending kind, the delay, the drive, the head and the result stalls using a seeded random stream. Directed cases add four situations: an index pulse during the wait, an address strobe and a second index in the same cycle, an abort during the wait, and rejected opcodes.

// File: rtl/fdc_rid_pkg.sv
package fdc_rid_pkg;
  localparam int DS_W      = 2;
  localparam int NUM_DRV   = 1 << DS_W;
  localparam int RES_BYTES = 7;
  localparam logic [7:0] OPC_MASK = 8'hBF;
  localparam logic [7:0] OPC_CODE = 8'h0A;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD2, S_DELAY, S_SEARCH, S_RESULT
  } rid_state_e;

  typedef enum logic [1:0] {
    END_OK, END_MISS, END_ABORT
  } rid_end_e;

  typedef struct packed {
    logic [7:0] trk;
    logic [7:0] hd;
    logic [7:0] sec;
    logic [7:0] sz;
  } rid_id_t;

  function automatic logic opc_hit(input logic [7:0] b);
    return (b & OPC_MASK) == OPC_CODE;
  endfunction
endpackage

// File: rtl/fdc_rid_delay.sv
module fdc_rid_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         run_i,
  output logic         last_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (load_i)               cnt <= val_i;
    else if (run_i && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last_o = run_i && (cnt == W'(1));

  // R3
  expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> $past(load_i || run_i));
endmodule

// File: rtl/fdc_rid_search.sv
module fdc_rid_search (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic index_i,
  input  logic am_i,
  output logic found_o,
  output logic miss_o
);
  logic idx_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                  idx_seen <= 1'b0;
    else if (!active_i)          idx_seen <= 1'b0;
    else if (index_i)            idx_seen <= 1'b1;
  end

  assign found_o = active_i && am_i;
  assign miss_o  = active_i && index_i && idx_seen && !am_i;

  // R4
  miss_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> $past(active_i));
endmodule

// File: rtl/fdc_rid_result.sv
module fdc_rid_result
  import fdc_rid_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  rid_end_e            kind_i,
  input  logic                hd_i,
  input  logic [DS_W-1:0]     ds_i,
  input  rid_id_t             id_i,
  input  logic                pop_i,
  output logic [7:0]          data_o,
  output logic                last_o
);
  localparam int PTR_W = $clog2(RES_BYTES);

  logic [7:0]       st0, st1;
  rid_id_t          id_q;
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st0  <= '0;
      st1  <= '0;
      id_q <= '0;
      ptr  <= '0;
    end else if (load_i) begin
      st0  <= {(kind_i == END_OK) ? 2'b00 : 2'b01, 3'b000, hd_i, ds_i};
      st1  <= (kind_i == END_MISS) ? 8'h01 : 8'h00;
      id_q <= (kind_i == END_OK) ? id_i : '0;
      ptr  <= '0;
    end else if (pop_i && !last_o) begin
      ptr  <= ptr + 1'b1;
    end
  end

  always_comb begin
    case (ptr)
      PTR_W'(0): data_o = st0;
      PTR_W'(1): data_o = st1;
      PTR_W'(2): data_o = 8'h00;
      PTR_W'(3): data_o = id_q.trk;
      PTR_W'(4): data_o = id_q.hd;
      PTR_W'(5): data_o = id_q.sec;
      default:   data_o = id_q.sz;
    endcase
  end

  assign last_o = (ptr == PTR_W'(RES_BYTES - 1));

  // R8
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(RES_BYTES - 1));
endmodule

// File: rtl/fdc_readid_seq.sv
module fdc_readid_seq
  import fdc_rid_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [7:0]               cmd_data,
  input  logic [NUM_DRV*DLY_W-1:0] dly_cfg,
  output logic                     sep_en,
  input  logic                     index_pulse,
  input  logic                     am_valid,
  input  logic [7:0]               am_track,
  input  logic [7:0]               am_head,
  input  logic [7:0]               am_sector,
  input  logic [7:0]               am_size,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [7:0]               res_data,
  output logic                     busy,
  output logic                     irq
);
  rid_state_e      state, nxt;
  logic            hd_q;
  logic [DS_W-1:0] ds_q;
  logic            cmd_fire, res_fire;
  logic [DLY_W-1:0] dly_sel;
  logic            dly_load, dly_last;
  logic            found, miss;
  logic            end_evt;
  rid_end_e        end_kind;
  logic            res_last;
  rid_id_t         am_id;

  assign cmd_ready = (state != S_RESULT);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign res_valid = (state == S_RESULT);
  assign res_fire  = res_valid && res_ready;
  assign sep_en    = (state == S_SEARCH);
  assign busy      = (state != S_IDLE);
  assign irq       = (state == S_RESULT);

  assign dly_sel  = dly_cfg[cmd_data[DS_W-1:0]*DLY_W +: DLY_W];
  assign dly_load = (state == S_CMD2) && cmd_fire;
  assign am_id    = '{trk: am_track, hd: am_head, sec: am_sector, sz: am_size};

  fdc_rid_delay #(.W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load_i(dly_load), .val_i(dly_sel),
    .run_i(state == S_DELAY), .last_o(dly_last)
  );

  fdc_rid_search u_search (
    .clk(clk), .rst_n(rst_n), .active_i(sep_en), .index_i(index_pulse),
    .am_i(am_valid), .found_o(found), .miss_o(miss)
  );

  always_comb begin
    end_evt  = 1'b0;
    end_kind = END_OK;
    if ((state == S_DELAY || state == S_SEARCH) && cmd_fire) begin
      end_evt  = 1'b1;
      end_kind = END_ABORT;
    end else if (found) begin
      end_evt  = 1'b1;
      end_kind = END_OK;
    end else if (miss) begin
      end_evt  = 1'b1;
      end_kind = END_MISS;
    end
  end

  fdc_rid_result u_result (
    .clk(clk), .rst_n(rst_n), .load_i(end_evt), .kind_i(end_kind),
    .hd_i(hd_q), .ds_i(ds_q), .id_i(am_id), .pop_i(res_fire),
    .data_o(res_data), .last_o(res_last)
  );

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:   if (cmd_fire && opc_hit(cmd_data)) nxt = S_CMD2;
      S_CMD2:   if (cmd_fire) nxt = (dly_sel == '0) ? S_SEARCH : S_DELAY;
      S_DELAY:  if (end_evt) nxt = S_RESULT;
                else if (dly_last) nxt = S_SEARCH;
      S_SEARCH: if (end_evt) nxt = S_RESULT;
      S_RESULT: if (res_fire && res_last) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      hd_q  <= 1'b0;
      ds_q  <= '0;
    end else begin
      state <= nxt;
      if (dly_load) begin
        hd_q <= cmd_data[2];
        ds_q <= cmd_data[DS_W-1:0];
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));
  // R9
  no_cmd_in_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cmd_ready);
  // R7
  irq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> busy);
  // R9
  sep_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sep_en |-> busy && !res_valid);
  // R7
  irq_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sep_en || state == S_DELAY));
endmodule

// File: tb/tb_fdc_readid_seq.sv
`timescale 1ns/1ps
module tb_fdc_readid_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_data = '0;
  logic [31:0] dly_cfg = '0;
  logic        sep_en;
  logic        index_pulse = 1'b0;
  logic        am_valid = 1'b0;
  logic [7:0]  am_track = '0, am_head = '0, am_sector = '0, am_size = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [7:0]  res_data;
  logic        busy, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fdc_readid_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .dly_cfg(dly_cfg), .sep_en(sep_en),
    .index_pulse(index_pulse), .am_valid(am_valid), .am_track(am_track),
    .am_head(am_head), .am_sector(am_sector), .am_size(am_size),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .busy(busy), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 normal, 1 missing mark, 2 abort
  function automatic logic [7:0] exp_byte(input int kind, input bit hd,
      input logic [1:0] ds, input logic [31:0] id, input int k);
    case (k)
      0: return {(kind == 0) ? 2'b00 : 2'b01, 3'b000, hd, ds};
      1: return (kind == 1) ? 8'h01 : 8'h00;
      2: return 8'h00;
      default: return (kind == 0) ? id[31-8*(k-3) -: 8] : 8'h00;
    endcase
  endfunction

  task automatic send_byte(input logic [7:0] b);
    cmd_data = b;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_index();
    index_pulse = 1'b1;
    @(negedge clk);
    index_pulse = 1'b0;
  endtask

  task automatic read_results(input int kind, input bit hd, input logic [1:0] ds,
      input logic [31:0] id);
    for (int k = 0; k < 7; k++) begin
      int stall = $urandom % 3;
      logic [7:0] e = exp_byte(kind, hd, ds, id, k);
      for (int s = 0; s < stall; s++) begin
        chk(res_valid && res_data == e, "R8 stall hold", res_data, e);
        @(negedge clk);
      end
      res_ready = 1'b1;
      chk(res_valid && res_data == e, (kind == 1) ? "R4/R8 byte" :
          (kind == 2) ? "R6/R8 byte" : "R5/R8 byte", res_data, e);
      if (k == 0) chk(res_data[2:0] == {hd, ds}, "R2 select echo", res_data[2:0], {hd, ds});
      @(posedge clk);
      @(negedge clk);
      res_ready = 1'b0;
    end
    chk(!busy && !irq && !res_valid && cmd_ready, "R10 back to idle",
        {busy, irq, res_valid, cmd_ready}, 4'b0001);
  endtask

  task automatic run_cmd(input int kind, input logic [1:0] ds, input bit hd,
      input logic [7:0] dval, input bit pre_idx, input bit mid_idx, input bit same_cyc);
    logic [31:0] id;
    int c;
    id = $urandom;
    dly_cfg[ds*8 +: 8] = dval;
    send_byte(($urandom % 2) ? 8'h4A : 8'h0A);
    chk(busy && !irq, "R1 opcode accepted", busy, 1);
    send_byte({3'($urandom), 2'b00, hd, ds});
    c = 0;
    while (!sep_en && c < 300) begin
      if (c == 0 && pre_idx) index_pulse = 1'b1;
      @(negedge clk);
      index_pulse = 1'b0;
      c++;
    end
    chk(c == int'(dval), "R3 wait length", c, dval);
    case (kind)
      0: begin
        if (mid_idx) begin
          pulse_index();
          chk(!irq && sep_en, "R4 first index keeps searching", irq, 0);
        end
        repeat ($urandom % 4) @(negedge clk);
        {am_track, am_head, am_sector, am_size} = id;
        am_valid = 1'b1;
        if (same_cyc) index_pulse = 1'b1;
        @(negedge clk);
        am_valid = 1'b0;
        index_pulse = 1'b0;
      end
      1: begin
        if (!pre_idx) repeat ($urandom % 3) @(negedge clk);
        pulse_index();
        chk(!irq && sep_en, "R4 first index keeps searching", irq, 0);
        repeat ($urandom % 5) @(negedge clk);
        pulse_index();
      end
      default: begin
        repeat ($urandom % 6) @(negedge clk);
        send_byte(8'($urandom));
      end
    endcase
    chk(irq && res_valid && !sep_en && !cmd_ready, "R7 irq at end",
        {irq, res_valid, sep_en, cmd_ready}, 4'b1100);
    read_results(kind, hd, ds, id);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] id0;
    void'($urandom(32'd7113));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !irq && !res_valid && !sep_en && cmd_ready, "R10 reset state",
        {busy, irq, res_valid, sep_en, cmd_ready}, 5'b00001);

    // R1: rejected opcodes
    send_byte(8'h0B);
    chk(!busy, "R1 reject 0B", busy, 0);
    send_byte(8'h8A);
    chk(!busy, "R1 reject 8A", busy, 0);
    send_byte(8'h2A);
    chk(!busy, "R1 reject 2A", busy, 0);

    // R6: abort during the wait
    dly_cfg[15:8] = 8'd20;
    send_byte(8'h0A);
    send_byte(8'h05);
    chk(!sep_en && busy, "R3 waiting", sep_en, 0);
    send_byte(8'hFF);
    chk(irq && !sep_en, "R6 abort in wait", irq, 1);
    id0 = '0;
    read_results(2, 1'b1, 2'd1, id0);

    // R5: mark and second index together, index during wait ignored
    run_cmd(0, 2'd2, 1'b0, 8'd3, 1'b1, 1'b1, 1'b1);
    // R4: index in the wait is not counted
    run_cmd(1, 2'd3, 1'b1, 8'd4, 1'b1, 1'b0, 1'b0);
    // R3: zero wait
    run_cmd(0, 2'd0, 1'b1, 8'd0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < 40; i++) begin
      int kind = $urandom % 3;
      logic [7:0] dv = 8'($urandom % 8);
      bit pre = (dv != 0) && ($urandom % 2);
      run_cmd(kind, 2'($urandom), 1'($urandom), dv, pre, 1'($urandom),
              1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule